// File: doc/BRIEF.md
# UART In-Band XON/XOFF Flow Controller

This block performs in-band (software) flow control for one UART channel. It sits between the byte-wide receive path and the receive FIFO, and beside the transmit serializer. On the receive side it looks at every byte the deserializer delivers. When it recognises a stop code it raises `tx_pause`, which halts the local transmitter. When it recognises a resume code it drops `tx_pause` again. Recognised flow-control bytes are removed from the data stream. Every other byte goes on to the FIFO.

On the transmit side the block watches the receive FIFO fill level. It asks the serializer to insert a stop code when the level reaches a high mark. It asks for a resume code when the level falls back to a low mark. A resume code is only requested after a stop code has been sent.

A 4-bit mode input selects the behaviour. Bits [3:2] select the transmit side: which of the four programmed characters are sent, one byte or two in a row. Bits [1:0] select receive matching. Depending on the transmit bits, receive setting 11 means either "either code counts" or "both codes in sequence". Software returns the mode to 0000 before it loads a new non-zero mode.

Top module: `swfc_ctrl`

## Requirements
- R1: After reset, `tx_pause`, `fifo_wr_en` and `ins_valid` are all 0.
- R2: With mode[1:0]=00, every received byte is written to the FIFO unchanged, one cycle after `rx_valid`, and `tx_pause` stays 0.
- R3: With mode[1:0]=10, a byte equal to `xoff1` sets `tx_pause` and a byte equal to `xon1` clears it, one cycle after `rx_valid`. Neither byte is written to the FIFO. `xon2` and `xoff2` pass through as data.
- R4: With mode[1:0]=01, `xoff2` and `xon2` act as in R3, and `xon1` and `xoff1` pass through as data.
- R5: With mode[1:0]=11 and mode[3:2] equal to 10 or 01, either stop code sets `tx_pause` and either resume code clears it. None of them is written to the FIFO. If a byte matches both a stop and a resume code, it counts as a stop code.
- R6: With mode[1:0]=11 and mode[3:2] equal to 11 or 00, `tx_pause` sets only on `xoff1` directly followed by `xoff2`, and clears only on `xon1` directly followed by `xon2`. A first byte is held back from the FIFO while it waits for its partner, and a completed pair is never written.
- R7: In the pair mode of R6, a held first byte followed by any other byte is written to the FIFO in the cycle after the breaking byte arrives. The breaking byte is then handled one cycle later as a fresh byte, and may itself start a new pair.
- R8: While mode[1:0]=00, `tx_pause` is 0 from the next cycle on.
- R9: With transmit enabled, one stop request is raised when `rx_level` >= `hi_thresh`. One resume request is raised when `rx_level` <= `lo_thresh`, and only after a stop was requested. A level that stays in place raises no second request.
- R10: A request appears on `ins_valid`/`ins_byte` one cycle after its trigger and holds until `ins_ack`. mode[3:2]=10 sends `xoff1`/`xon1`, and 01 sends `xoff2`/`xon2`. Mode 11 sends `xoff1` then `xoff2` (or `xon1` then `xon2`), with the second byte valid in the cycle right after the first is acknowledged.
- R11: With mode[3:2]=00, `ins_valid` stays 0 whatever the fill level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode | input | 4 | [3:2] transmit select, [1:0] receive select |
| xon1 | input | 8 | First resume character |
| xon2 | input | 8 | Second resume character |
| xoff1 | input | 8 | First stop character |
| xoff2 | input | 8 | Second stop character |
| rx_valid | input | 1 | Received byte strobe from the deserializer |
| rx_byte | input | 8 | Received byte |
| fifo_wr_en | output | 1 | Write strobe to the receive FIFO |
| fifo_wr_data | output | 8 | Byte written to the receive FIFO |
| tx_pause | output | 1 | Holds the local transmitter |
| rx_level | input | 6 | Receive FIFO fill level |
| hi_thresh | input | 6 | Level that triggers a stop request |
| lo_thresh | input | 6 | Level that triggers a resume request |
| ins_valid | output | 1 | Flow-control byte waiting to be inserted |
| ins_byte | output | 8 | Flow-control byte to insert |
| ins_ack | input | 1 | Serializer has taken `ins_byte` at a character boundary |

## Verification
The assertions rely on four properties of the inputs:
- `rx_valid` never pulses in two adjacent cycles. A real deserializer is many cycles apart per byte, and the replay slot of R7 depends on this.
- `ins_ack` is only raised while `ins_valid` is high.
- The mode passes through 0000 between two non-zero settings.
- The four characters do not change while a mode is active.

The directed bench follows all four. It drives each byte as a one-cycle pulse followed by idle cycles. It acknowledges only offered bytes. It loads every mode through a zero step with settle cycles, and it programs the characters once.

// File: rtl/swfc_pkg.sv
// Shared types for the in-band flow controller.
// Assumes: mode[3:2] is the transmit select and mode[1:0] the receive select.
package swfc_pkg;

    typedef enum logic [1:0] {RXS_IDLE, RXS_ON1, RXS_OFF1} rx_state_t;
    typedef enum logic [1:0] {TXS_IDLE, TXS_FIRST, TXS_SECOND} tx_state_t;

    typedef struct packed {
        logic en;    // receive flow control active
        logic use1;  // single-byte match against xon1/xoff1
        logic use2;  // single-byte match against xon2/xoff2
        logic dual;  // two-byte sequence match
    } rx_cfg_t;

    // Decode the receive behaviour; it depends on the transmit bits when rx=11.
    function automatic rx_cfg_t decode_rx(input logic [3:0] m);
        rx_cfg_t c;
        c = '0;
        case (m[1:0])
            2'b10: begin c.en = 1'b1; c.use1 = 1'b1; end
            2'b01: begin c.en = 1'b1; c.use2 = 1'b1; end
            2'b11: begin
                c.en = 1'b1;
                if (m[3] ^ m[2]) begin
                    c.use1 = 1'b1;
                    c.use2 = 1'b1;
                end else begin
                    c.dual = 1'b1;
                end
            end
            default: c = '0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/swfc_rx_match.sv
// Receive-side matcher: filters flow-control bytes out of the received stream
// and drives the transmit pause flag.
// Assumes: rx_valid never asserts in two consecutive cycles (a one-entry replay
// slot reprocesses a byte that broke a pending pair in the following cycle).
module swfc_rx_match
    import swfc_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  rx_cfg_t       cfg,
    input  logic [DW-1:0] xon1,
    input  logic [DW-1:0] xon2,
    input  logic [DW-1:0] xoff1,
    input  logic [DW-1:0] xoff2,
    input  logic          rx_valid,
    input  logic [DW-1:0] rx_byte,
    output logic          fifo_wr_en,
    output logic [DW-1:0] fifo_wr_data,
    output logic          tx_pause
);

    rx_state_t     state_q, state_d;
    logic [DW-1:0] held_q, held_d;
    logic          rep_v_q, rep_v_d;
    logic [DW-1:0] rep_b_q, rep_b_d;
    logic          cur_v;
    logic [DW-1:0] cur_b;
    logic          wr_d;
    logic [DW-1:0] wdata_d;
    logic          hit_on, hit_off;
    logic [DW-1:0] want2;

    assign cur_v = rx_valid | rep_v_q;
    assign cur_b = rep_v_q ? rep_b_q : rx_byte;
    assign want2 = (state_q == RXS_ON1) ? xon2 : xoff2;

    // Classify the current byte and choose the FIFO write and next match state.
    always_comb begin
        state_d = state_q;
        held_d  = held_q;
        rep_v_d = 1'b0;
        rep_b_d = rep_b_q;
        wr_d    = 1'b0;
        wdata_d = cur_b;
        hit_on  = 1'b0;
        hit_off = 1'b0;
        if (!cfg.dual) begin
            state_d = RXS_IDLE;
            if (state_q != RXS_IDLE) begin
                wr_d    = 1'b1;
                wdata_d = held_q;
                if (cur_v) begin
                    rep_v_d = 1'b1;
                    rep_b_d = cur_b;
                end
            end else if (cur_v) begin
                if (cfg.en && ((cfg.use1 && cur_b == xoff1) || (cfg.use2 && cur_b == xoff2)))
                    hit_off = 1'b1;
                else if (cfg.en && ((cfg.use1 && cur_b == xon1) || (cfg.use2 && cur_b == xon2)))
                    hit_on = 1'b1;
                else
                    wr_d = 1'b1;
            end
        end else if (cur_v) begin
            if (state_q == RXS_IDLE) begin
                if (cur_b == xoff1) begin
                    state_d = RXS_OFF1;
                    held_d  = cur_b;
                end else if (cur_b == xon1) begin
                    state_d = RXS_ON1;
                    held_d  = cur_b;
                end else begin
                    wr_d = 1'b1;
                end
            end else begin
                state_d = RXS_IDLE;
                if (cur_b == want2) begin
                    hit_on  = (state_q == RXS_ON1);
                    hit_off = (state_q == RXS_OFF1);
                end else begin
                    wr_d    = 1'b1;
                    wdata_d = held_q;
                    rep_v_d = 1'b1;
                    rep_b_d = cur_b;
                end
            end
        end
    end

    // Register match state, replay slot, FIFO write and pause flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q      <= RXS_IDLE;
            held_q       <= '0;
            rep_v_q      <= 1'b0;
            rep_b_q      <= '0;
            fifo_wr_en   <= 1'b0;
            fifo_wr_data <= '0;
            tx_pause     <= 1'b0;
        end else begin
            state_q      <= state_d;
            held_q       <= held_d;
            rep_v_q      <= rep_v_d;
            rep_b_q      <= rep_b_d;
            fifo_wr_en   <= wr_d;
            fifo_wr_data <= wdata_d;
            if (!cfg.en)      tx_pause <= 1'b0;
            else if (hit_off) tx_pause <= 1'b1;
            else if (hit_on)  tx_pause <= 1'b0;
        end
    end

endmodule

// File: rtl/swfc_tx_req.sv
// Transmit-side requester: raises stop/resume insertion requests from the
// receive FIFO level and walks one- or two-byte sequences through the serializer.
// Assumes: ins_ack only while ins_valid; characters constant while enabled.
module swfc_tx_req
    import swfc_pkg::*;
#(
    parameter int DW = 8,
    parameter int LW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    tx_mode,
    input  logic [DW-1:0] xon1,
    input  logic [DW-1:0] xon2,
    input  logic [DW-1:0] xoff1,
    input  logic [DW-1:0] xoff2,
    input  logic [LW-1:0] rx_level,
    input  logic [LW-1:0] hi_thresh,
    input  logic [LW-1:0] lo_thresh,
    input  logic          ins_ack,
    output logic          ins_valid,
    output logic [DW-1:0] ins_byte,
    output logic          second
);

    tx_state_t st_q;
    logic      kind_off_q;
    logic      sent_off_q;
    logic      en, dual, sel2;

    assign en   = (tx_mode != 2'b00);
    assign dual = (tx_mode == 2'b11);
    assign sel2 = (tx_mode == 2'b01);

    // Trigger requests from the fill level and step through the byte sequence.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            st_q       <= TXS_IDLE;
            kind_off_q <= 1'b0;
            sent_off_q <= 1'b0;
        end else begin
            case (st_q)
                TXS_IDLE: begin
                    if (!sent_off_q && rx_level >= hi_thresh) begin
                        st_q       <= TXS_FIRST;
                        kind_off_q <= 1'b1;
                        sent_off_q <= 1'b1;
                    end else if (sent_off_q && rx_level <= lo_thresh) begin
                        st_q       <= TXS_FIRST;
                        kind_off_q <= 1'b0;
                        sent_off_q <= 1'b0;
                    end
                end
                TXS_FIRST:  if (ins_ack) st_q <= dual ? TXS_SECOND : TXS_IDLE;
                TXS_SECOND: if (ins_ack) st_q <= TXS_IDLE;
                default:    st_q <= TXS_IDLE;
            endcase
        end
    end

    // Select the character offered to the serializer.
    always_comb begin
        ins_byte = '0;
        if (st_q == TXS_FIRST)
            ins_byte = kind_off_q ? (sel2 ? xoff2 : xoff1) : (sel2 ? xon2 : xon1);
        else if (st_q == TXS_SECOND)
            ins_byte = kind_off_q ? xoff2 : xon2;
    end

    assign ins_valid = (st_q != TXS_IDLE);
    assign second    = (st_q == TXS_SECOND);

endmodule

// File: rtl/swfc_ctrl.sv
// Top of the in-band flow controller for one UART channel: decodes the mode
// field and joins the receive matcher with the transmit requester.
// Assumes: mode is cleared to zero before any new non-zero value is loaded.
module swfc_ctrl
    import swfc_pkg::*;
#(
    parameter int DW = 8,
    parameter int LW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [3:0]    mode,
    input  logic [DW-1:0] xon1,
    input  logic [DW-1:0] xon2,
    input  logic [DW-1:0] xoff1,
    input  logic [DW-1:0] xoff2,
    input  logic          rx_valid,
    input  logic [DW-1:0] rx_byte,
    output logic          fifo_wr_en,
    output logic [DW-1:0] fifo_wr_data,
    output logic          tx_pause,
    input  logic [LW-1:0] rx_level,
    input  logic [LW-1:0] hi_thresh,
    input  logic [LW-1:0] lo_thresh,
    output logic          ins_valid,
    output logic [DW-1:0] ins_byte,
    input  logic          ins_ack
);

    rx_cfg_t rx_cfg;
    logic    tx_second;

    assign rx_cfg = decode_rx(mode);

    swfc_rx_match #(.DW(DW)) u_rx (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg          (rx_cfg),
        .xon1         (xon1),
        .xon2         (xon2),
        .xoff1        (xoff1),
        .xoff2        (xoff2),
        .rx_valid     (rx_valid),
        .rx_byte      (rx_byte),
        .fifo_wr_en   (fifo_wr_en),
        .fifo_wr_data (fifo_wr_data),
        .tx_pause     (tx_pause)
    );

    swfc_tx_req #(.DW(DW), .LW(LW)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .tx_mode   (mode[3:2]),
        .xon1      (xon1),
        .xon2      (xon2),
        .xoff1     (xoff1),
        .xoff2     (xoff2),
        .rx_level  (rx_level),
        .hi_thresh (hi_thresh),
        .lo_thresh (lo_thresh),
        .ins_ack   (ins_ack),
        .ins_valid (ins_valid),
        .ins_byte  (ins_byte),
        .second    (tx_second)
    );

endmodule

// File: rtl/swfc_ctrl_chk.sv
// Property checker for swfc_ctrl, attached by bind; observes ports and the
// requester's second-byte flag.
module swfc_ctrl_chk #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic [3:0]    mode,
    input logic [DW-1:0] xoff1,
    input logic          rx_valid,
    input logic [DW-1:0] rx_byte,
    input logic          fifo_wr_en,
    input logic          tx_pause,
    input logic          ins_valid,
    input logic          ins_ack,
    input logic [DW-1:0] ins_byte,
    input logic          tx_second
);

    // R7 input rule: received bytes are never on adjacent cycles
    a_r7_rx_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    // R10 input rule: acknowledge only an offered byte
    a_r10_ack_valid: assert property (@(posedge clk) disable iff (!rst_n)
        ins_ack |-> ins_valid);

    // R3: single-code stop pauses and is not forwarded
    a_r3_xoff1_stops: assert property (@(posedge clk) disable iff (!rst_n)
        (mode[1:0] == 2'b10 && $stable(mode) && rx_valid && rx_byte == xoff1)
        |=> (tx_pause && !fifo_wr_en));

    // R8: receive flow control off clears the pause
    a_r8_pause_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (mode[1:0] == 2'b00) |=> !tx_pause);

    // R10: the second byte of a pair follows the first at once
    a_r10_pair_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (mode[3:2] == 2'b11 && $stable(mode) && ins_valid && ins_ack && !tx_second)
        |=> (ins_valid && tx_second));

    // R10: an unacknowledged byte stays put
    a_r10_hold_byte: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_valid && !ins_ack) |=> (!ins_valid || $stable(ins_byte)));

    // R11: transmit disabled never requests
    a_r11_tx_off: assert property (@(posedge clk) disable iff (!rst_n)
        (mode[3:2] == 2'b00) |=> !ins_valid);

endmodule

bind swfc_ctrl swfc_ctrl_chk #(.DW(DW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode       (mode),
    .xoff1      (xoff1),
    .rx_valid   (rx_valid),
    .rx_byte    (rx_byte),
    .fifo_wr_en (fifo_wr_en),
    .tx_pause   (tx_pause),
    .ins_valid  (ins_valid),
    .ins_ack    (ins_ack),
    .ins_byte   (ins_byte),
    .tx_second  (tx_second)
);

// File: tb/swfc_ctrl_tb.sv
// Directed bench for swfc_ctrl: one task per scenario, each checking itself.
module swfc_ctrl_tb;

    localparam logic [7:0] XON1 = 8'h11, XON2 = 8'h91, XOFF1 = 8'h13, XOFF2 = 8'h93;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] mode = 4'h0;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_byte = 8'h00;
    logic       fifo_wr_en;
    logic [7:0] fifo_wr_data;
    logic       tx_pause;
    logic [5:0] rx_level = 6'd0;
    logic [5:0] hi_thresh = 6'd12;
    logic [5:0] lo_thresh = 6'd4;
    logic       ins_valid;
    logic [7:0] ins_byte;
    logic       ins_ack = 1'b0;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    logic [7:0] got_q[$];

    always #10 clk = ~clk;

    swfc_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .mode(mode),
        .xon1(XON1), .xon2(XON2), .xoff1(XOFF1), .xoff2(XOFF2),
        .rx_valid(rx_valid), .rx_byte(rx_byte),
        .fifo_wr_en(fifo_wr_en), .fifo_wr_data(fifo_wr_data), .tx_pause(tx_pause),
        .rx_level(rx_level), .hi_thresh(hi_thresh), .lo_thresh(lo_thresh),
        .ins_valid(ins_valid), .ins_byte(ins_byte), .ins_ack(ins_ack)
    );

    // Record every FIFO write, sampled between edges
    always @(negedge clk) if (rst_n && fifo_wr_en) got_q.push_back(fifo_wr_data);

    // Watchdog
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 100000) begin
            checks++; errors++;
            $display("FAIL watchdog: act=%0d cycles exp=finish earlier", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic set_mode(input logic [3:0] m);
        @(negedge clk) mode = 4'h0;
        wait_cyc(3);
        mode = m;
        wait_cyc(3);
        got_q.delete();
    endtask

    task automatic send(input logic [7:0] b);
        @(negedge clk);
        rx_valid = 1'b1; rx_byte = b;
        @(negedge clk) rx_valid = 1'b0;
        wait_cyc(3);
    endtask

    // exp holds up to four bytes, first byte in [7:0]
    task automatic check_got(input string tag, input int n, input logic [31:0] exp);
        check({tag, " count"}, got_q.size(), n);
        for (int i = 0; i < n && i < got_q.size(); i++)
            check({tag, " byte"}, got_q[i], exp[8*i +: 8]);
    endtask

    task automatic ack_once();
        @(negedge clk) ins_ack = 1'b1;
        @(negedge clk) ins_ack = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 pause", tx_pause, 0);
        check("R1 fifo_wr_en", fifo_wr_en, 0);
        check("R1 ins_valid", ins_valid, 0);
    endtask

    task automatic t_rx_off();
        set_mode(4'b0000);
        send(XOFF1); send(XON1); send(8'h41);
        check_got("R2 passthrough", 3, {8'h0, 8'h41, XON1, XOFF1});
        check("R2 pause", tx_pause, 0);
    endtask

    task automatic t_rx_single1();
        set_mode(4'b0010);
        send(XOFF1);
        check("R3 xoff1 pause", tx_pause, 1);
        send(XOFF2);
        check("R3 xoff2 no effect", tx_pause, 1);
        send(XON1);
        check("R3 xon1 resume", tx_pause, 0);
        check_got("R3 filtered", 1, {24'h0, XOFF2});
    endtask

    task automatic t_rx_single2();
        set_mode(4'b0001);
        send(XOFF2);
        check("R4 xoff2 pause", tx_pause, 1);
        send(XOFF1);
        send(XON2);
        check("R4 xon2 resume", tx_pause, 0);
        check_got("R4 filtered", 1, {24'h0, XOFF1});
    endtask

    task automatic t_rx_either(input logic [3:0] m);
        set_mode(m);
        send(XOFF2);
        check("R5 xoff2 pause", tx_pause, 1);
        send(XON1);
        check("R5 xon1 resume", tx_pause, 0);
        send(XOFF1);
        check("R5 xoff1 pause", tx_pause, 1);
        send(XON2);
        check("R5 xon2 resume", tx_pause, 0);
        check_got("R5 none forwarded", 0, 32'h0);
    endtask

    task automatic t_rx_dual(input logic [3:0] m);
        set_mode(m);
        send(XOFF1);
        check("R6 first held pause", tx_pause, 0);
        check("R6 first held fifo", got_q.size(), 0);
        send(XOFF2);
        check("R6 pair pause", tx_pause, 1);
        send(XON1); send(XON2);
        check("R6 pair resume", tx_pause, 0);
        check_got("R6 none forwarded", 0, 32'h0);
    endtask

    task automatic t_rx_broken();
        set_mode(4'b0011);
        send(XOFF1); send(8'h41);
        check_got("R7 release", 2, {16'h0, 8'h41, XOFF1});
        check("R7 no pause", tx_pause, 0);
        got_q.delete();
        send(XON1); send(XOFF1); send(XOFF2);
        check_got("R7 restart", 1, {24'h0, XON1});
        check("R7 restart pause", tx_pause, 1);
        got_q.delete();
        send(XON1); send(XON1); send(XON2);
        check_got("R7 repeat first", 1, {24'h0, XON1});
        check("R7 repeat resume", tx_pause, 0);
    endtask

    task automatic t_rx_disable();
        set_mode(4'b0010);
        send(XOFF1);
        check("R8 paused", tx_pause, 1);
        @(negedge clk) mode = 4'b0000;
        @(negedge clk);
        check("R8 cleared", tx_pause, 0);
    endtask

    task automatic t_tx(input logic [3:0] m, input logic [7:0] f1, input logic [7:0] f2,
                        input logic [7:0] n1, input logic [7:0] n2, input logic dual);
        set_mode(m);
        rx_level = 6'd0;
        wait_cyc(2);
        check("R9 no xon before xoff", ins_valid, 0);
        @(negedge clk) rx_level = 6'd12;
        @(negedge clk);
        check("R9 xoff request", ins_valid, 1);
        check("R10 xoff byte", ins_byte, f1);
        ack_once();
        if (dual) begin
            check("R10 second valid", ins_valid, 1);
            check("R10 second byte", ins_byte, f2);
            ack_once();
        end
        check("R10 done", ins_valid, 0);
        wait_cyc(3);
        check("R9 xoff once", ins_valid, 0);
        @(negedge clk) rx_level = 6'd8;
        wait_cyc(2);
        check("R9 between marks", ins_valid, 0);
        @(negedge clk) rx_level = 6'd4;
        @(negedge clk);
        check("R9 xon request", ins_valid, 1);
        check("R10 xon byte", ins_byte, n1);
        ack_once();
        if (dual) begin
            check("R10 xon second", ins_byte, n2);
            ack_once();
        end
        wait_cyc(3);
        check("R9 xon once", ins_valid, 0);
        rx_level = 6'd0;
    endtask

    task automatic t_tx_off();
        set_mode(4'b0000);
        @(negedge clk) rx_level = 6'd20;
        wait_cyc(3);
        check("R11 no request", ins_valid, 0);
        rx_level = 6'd0;
    endtask

    initial begin
        wait_cyc(3);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_rx_off();
        t_rx_single1();
        t_rx_single2();
        t_rx_either(4'b1011);
        t_rx_either(4'b0111);
        t_rx_dual(4'b0011);
        t_rx_dual(4'b1111);
        t_rx_broken();
        t_rx_disable();
        t_tx(4'b1000, XOFF1, XOFF1, XON1, XON1, 1'b0);
        t_tx(4'b0100, XOFF2, XOFF2, XON2, XON2, 1'b0);
        t_tx(4'b1100, XOFF1, XOFF2, XON1, XON2, 1'b1);
        t_tx_off();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule